// File: doc/BRIEF.md
# Bundle Group Issue Sequencer

This block takes a stream of 128-bit instruction bundles and turns them into issue cycles for a machine that is `ISSUE_W` lanes wide. Every bundle holds a 5-bit template and three 41-bit operation slots. The template has two jobs. It marks which slots close an explicitly parallel group. It can also fuse the second and third slots into one long-immediate operation. A group may span bundles. A group wider than the machine is issued over several cycles in slot order.

Decoded operations go into a circular buffer that holds two bundles' worth of operations. The issue side presents one chunk per cycle on a valid/ready handshake. A chunk never holds operations from two groups. The chunk that completes a group raises a group-end flag, and it may leave lanes idle. The bundle side uses its own valid/ready handshake. Bundles with an undefined template are accepted and dropped, and a one-cycle flag reports them.

Top module: `bundle_group_issuer`

## Requirements
- R1: The template is `inBundle[4:0]`. Slot 0 is `[45:5]`, slot 1 is `[86:46]` and slot 2 is `[127:87]`. Operations of a group leave in slot order, bundle after bundle, and the oldest operation goes on lane 0.
- R2: When template bit 3 is set, slots 1 and 2 are issued as one operation. Its 82-bit lane data is `{slot2, slot1}` and its `issueLong` bit is 1. Any other operation carries its slot in lane bits [40:0], with the upper 41 bits at zero and `issueLong` at 0.
- R3: A template is illegal when bit 4 is set, or when bits 3 and 1 are both set. Such a bundle is accepted but adds no operations. `illegalBundle` is 1 for exactly the cycle after the bundle is accepted, and 0 at all other times.
- R4: Template bits 0, 1 and 2 mark a group stop after slot 0, 1 and 2; with a merge, bit 2 marks the stop after the merged operation. A chunk ends at the first stop among the buffered operations. Lanes after that operation have `issueLaneValid` at 0 and zero data.
- R5: A chunk that does not end a group fills all `ISSUE_W` lanes. `issueValid` is 1 exactly when a stop lies within the first `ISSUE_W` buffered operations, or when at least `ISSUE_W` operations are buffered.
- R6: `issueGroupEnd` is 1 exactly on the chunk that carries the last operation of a group. A group longer than `ISSUE_W` therefore takes several chunks, and only the final one is flagged.
- R7: While `issueValid` is 1 and `issueReady` is 0, the chunk holds steady in the next cycle: lane valids, lane data, long flags and group end stay the same.
- R8: The buffer holds `3*BUF_BUNDLES` operations. `inReady` is 1 exactly when at most `3*BUF_BUNDLES-3` operations are buffered.
- R9: A synchronous `syncRst` empties the buffer and drops any partly issued group. After it, `issueValid` is 0, `inReady` is 1 and `illegalBundle` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| syncRst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Bundle offered |
| inReady | output | 1 | Room for a full bundle |
| inBundle | input | 128 | Template and three slots |
| illegalBundle | output | 1 | Previous accepted bundle had an undefined template |
| issueValid | output | 1 | Chunk presented |
| issueReady | input | 1 | Chunk taken this cycle |
| issueLaneValid | output | ISSUE_W | Per-lane occupancy, lane 0 first |
| issueOp | output | ISSUE_W*82 | Lane data, lane i at bits [82*i+81:82*i] |
| issueLong | output | ISSUE_W | Lane carries a merged long-immediate operation |
| issueGroupEnd | output | 1 | Chunk completes a group |

## Verification
The bench builds the block with `ISSUE_W=3` and `BUF_BUNDLES=2`, so the buffer holds six operations. With three lanes, a stop can fall on any lane, so idle trailing lanes occur in every position. A group of exactly one bundle fits a chunk precisely. Merged long operations shift later stops onto unusual lanes. Long spells with `issueReady` held low fill the six-entry buffer, so `inReady` spends real time at both values, and chunks stay held across many stalled cycles.

// File: rtl/bgis_pkg.sv
package bgis_pkg;
  localparam int SLOT_W   = 41;
  localparam int TMPL_W   = 5;
  localparam int BUNDLE_W = 128;
  localparam int OP_W     = 2 * SLOT_W;
  localparam int SLOTS    = 3;

  typedef struct packed {
    logic [OP_W-1:0] data;
    logic            isLong;
    logic            stop;
  } op_t;

  typedef struct packed {
    op_t [SLOTS-1:0] ops;
    logic [1:0]      count;
    logic            illegal;
  } decoded_t;

  // Control-to-datapath strobes
  typedef struct packed {
    logic accept;
    logic clear;
  } strobe_t;

  function automatic decoded_t decodeBundle(input logic [BUNDLE_W-1:0] b);
    decoded_t d;
    logic [TMPL_W-1:0] t;
    logic [SLOT_W-1:0] s0, s1, s2;
    t  = b[TMPL_W-1:0];
    s0 = b[TMPL_W +: SLOT_W];
    s1 = b[TMPL_W+SLOT_W +: SLOT_W];
    s2 = b[TMPL_W+2*SLOT_W +: SLOT_W];
    d = '0;
    d.illegal = t[4] | (t[3] & t[1]);
    d.ops[0] = '{data: {{SLOT_W{1'b0}}, s0}, isLong: 1'b0, stop: t[0]};
    if (t[3]) begin
      d.ops[1] = '{data: {s2, s1}, isLong: 1'b1, stop: t[2]};
      d.count  = 2'd2;
    end else begin
      d.ops[1] = '{data: {{SLOT_W{1'b0}}, s1}, isLong: 1'b0, stop: t[1]};
      d.ops[2] = '{data: {{SLOT_W{1'b0}}, s2}, isLong: 1'b0, stop: t[2]};
      d.count  = 2'd3;
    end
    if (d.illegal) d.count = 2'd0;
    return d;
  endfunction
endpackage

// File: rtl/bgis_datapath.sv
module bgis_datapath
  import bgis_pkg::*;
#(
  parameter int ISSUE_W = 2,
  parameter int DEPTH   = 6,
  parameter int PTR_W   = 3,
  parameter int CNT_W   = 3
) (
  input  logic                    clk,
  input  logic [BUNDLE_W-1:0]     inBundle,
  input  strobe_t                 strobes,
  input  logic [PTR_W-1:0]        wrPtr,
  input  logic [PTR_W-1:0]        rdPtr,
  input  logic [ISSUE_W-1:0]      laneValid,
  output logic [1:0]              pushCount,
  output logic [ISSUE_W-1:0]      headStop,
  output logic [ISSUE_W*OP_W-1:0] issueOp,
  output logic [ISSUE_W-1:0]      issueLong,
  output logic                    illegalBundle
);
  localparam int SUM_W = PTR_W + 2;

  function automatic logic [PTR_W-1:0] wrapAdd(input logic [PTR_W-1:0] p, input logic [CNT_W-1:0] k);
    logic [SUM_W-1:0] s;
    s = SUM_W'(p) + SUM_W'(k);
    if (s >= SUM_W'(DEPTH)) s = s - SUM_W'(DEPTH);
    return s[PTR_W-1:0];
  endfunction

  decoded_t dec;
  op_t      mem [DEPTH];

  assign dec       = decodeBundle(inBundle);
  assign pushCount = dec.count;

  always_ff @(posedge clk) begin
    for (int k = 0; k < SLOTS; k++) begin
      if (strobes.accept && !dec.illegal && (k < int'(dec.count)))
        mem[wrapAdd(wrPtr, CNT_W'(k))] <= dec.ops[k];
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.clear) illegalBundle <= 1'b0;
    else               illegalBundle <= strobes.accept & dec.illegal;
  end

  generate
    for (genvar i = 0; i < ISSUE_W; i++) begin : g_lane
      op_t entry;
      assign entry       = mem[wrapAdd(rdPtr, CNT_W'(i))];
      assign headStop[i] = entry.stop;
      assign issueOp[i*OP_W +: OP_W] = laneValid[i] ? entry.data : '0;
      assign issueLong[i] = laneValid[i] & entry.isLong;
    end
  endgenerate

  // R3: the flag only follows an accepted bundle
  p_illegal_after_accept_r3: assert property (@(posedge clk) disable iff (strobes.clear)
    illegalBundle |-> $past(strobes.accept));
endmodule

// File: rtl/bgis_control.sv
module bgis_control
  import bgis_pkg::*;
#(
  parameter int ISSUE_W = 2,
  parameter int DEPTH   = 6,
  parameter int PTR_W   = 3,
  parameter int CNT_W   = 3
) (
  input  logic               clk,
  input  logic               syncRst,
  input  logic               inValid,
  input  logic               issueReady,
  input  logic [1:0]         pushCount,
  input  logic [ISSUE_W-1:0] headStop,
  output logic               inReady,
  output strobe_t            strobes,
  output logic [PTR_W-1:0]   wrPtr,
  output logic [PTR_W-1:0]   rdPtr,
  output logic               issueValid,
  output logic [ISSUE_W-1:0] laneValid,
  output logic               groupEnd
);
  localparam int SUM_W = PTR_W + 2;

  function automatic logic [PTR_W-1:0] wrapAdd(input logic [PTR_W-1:0] p, input logic [CNT_W-1:0] k);
    logic [SUM_W-1:0] s;
    s = SUM_W'(p) + SUM_W'(k);
    if (s >= SUM_W'(DEPTH)) s = s - SUM_W'(DEPTH);
    return s[PTR_W-1:0];
  endfunction

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] chunkLen;
  logic             accept, pop;
  logic [CNT_W-1:0] pushAdd, popSub;

  always_comb begin
    chunkLen = '0;
    groupEnd = 1'b0;
    for (int i = 0; i < ISSUE_W; i++) begin
      if (!groupEnd && (CNT_W'(i) < count) && headStop[i]) begin
        groupEnd = 1'b1;
        chunkLen = CNT_W'(i + 1);
      end
    end
    if (!groupEnd && count >= CNT_W'(ISSUE_W)) chunkLen = CNT_W'(ISSUE_W);
    for (int i = 0; i < ISSUE_W; i++) laneValid[i] = CNT_W'(i) < chunkLen;
  end

  assign issueValid     = chunkLen != '0;
  assign inReady        = count <= CNT_W'(DEPTH - SLOTS);
  assign accept         = inValid & inReady;
  assign pop            = issueValid & issueReady;
  assign pushAdd        = accept ? CNT_W'(pushCount) : '0;
  assign popSub         = pop ? chunkLen : '0;
  assign strobes.accept = accept;
  assign strobes.clear  = syncRst;

  always_ff @(posedge clk) begin
    if (syncRst) begin
      count <= '0;
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      count <= count + pushAdd - popSub;
      wrPtr <= wrapAdd(wrPtr, pushAdd);
      rdPtr <= wrapAdd(rdPtr, popSub);
    end
  end

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (syncRst)
    count <= CNT_W'(DEPTH));
  p_hold_stall_r7: assert property (@(posedge clk) disable iff (syncRst)
    issueValid && !issueReady |=> issueValid && $stable(laneValid) && $stable(rdPtr) && $stable(groupEnd));
  p_full_chunk_r5: assert property (@(posedge clk) disable iff (syncRst)
    issueValid && !groupEnd |-> &laneValid);
  p_reset_empty_r9: assert property (@(posedge clk) disable iff (syncRst)
    $past(syncRst) |-> !issueValid && inReady);
endmodule

// File: rtl/bundle_group_issuer.sv
module bundle_group_issuer
  import bgis_pkg::*;
#(
  parameter int ISSUE_W     = 2,
  parameter int BUF_BUNDLES = 2
) (
  input  logic                    clk,
  input  logic                    syncRst,
  input  logic                    inValid,
  output logic                    inReady,
  input  logic [127:0]            inBundle,
  output logic                    illegalBundle,
  output logic                    issueValid,
  input  logic                    issueReady,
  output logic [ISSUE_W-1:0]      issueLaneValid,
  output logic [ISSUE_W*82-1:0]   issueOp,
  output logic [ISSUE_W-1:0]      issueLong,
  output logic                    issueGroupEnd
);
  localparam int DEPTH = BUF_BUNDLES * SLOTS;
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  strobe_t            strobes;
  logic [PTR_W-1:0]   wrPtr, rdPtr;
  logic [1:0]         pushCount;
  logic [ISSUE_W-1:0] headStop;

  bgis_control #(.ISSUE_W(ISSUE_W), .DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .syncRst(syncRst), .inValid(inValid), .issueReady(issueReady),
    .pushCount(pushCount), .headStop(headStop), .inReady(inReady), .strobes(strobes),
    .wrPtr(wrPtr), .rdPtr(rdPtr), .issueValid(issueValid), .laneValid(issueLaneValid),
    .groupEnd(issueGroupEnd)
  );

  bgis_datapath #(.ISSUE_W(ISSUE_W), .DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .inBundle(inBundle), .strobes(strobes), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .laneValid(issueLaneValid), .pushCount(pushCount), .headStop(headStop),
    .issueOp(issueOp), .issueLong(issueLong), .illegalBundle(illegalBundle)
  );
endmodule

// File: tb/bundle_group_issuer_tb.sv
module bundle_group_issuer_tb;
  localparam int W = 3;
  localparam int NB = 2;
  localparam int OPW = 82;
  localparam int LIMIT = 100000;

  logic clk = 1'b0;
  logic syncRst, inValid, inReady, illegalBundle, issueValid, issueReady, issueGroupEnd;
  logic [127:0] inBundle;
  logic [W-1:0] issueLaneValid, issueLong;
  logic [W*OPW-1:0] issueOp;

  always #2 clk = ~clk;

  bundle_group_issuer #(.ISSUE_W(W), .BUF_BUNDLES(NB)) u_dut (.*);

  logic [OPW-1:0] qOp[$];
  bit qLong[$];
  bit qStop[$];
  int checks = 0, errors = 0, cyc = 0, acc = 0, nTarget = 1200;
  bit expIll = 0, prevStall = 0, prevEnd = 0;
  logic [W*OPW-1:0] prevOp;
  logic [W-1:0] prevMask, prevLong;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [40:0] rnd41();
    logic [63:0] r;
    r = {$urandom(), $urandom()};
    return r[40:0];
  endfunction

  function automatic logic [127:0] mkBundle(input logic [4:0] t);
    return {rnd41(), rnd41(), rnd41(), t};
  endfunction

  function automatic bit isIllegal(input logic [4:0] t);
    return t[4] | (t[3] & t[1]);
  endfunction

  task automatic pushModel(input logic [127:0] b);
    logic [4:0] t;
    t = b[4:0];
    if (isIllegal(t)) return;
    qOp.push_back({41'b0, b[45:5]}); qLong.push_back(0); qStop.push_back(t[0]);
    if (t[3]) begin
      qOp.push_back({b[127:87], b[86:46]}); qLong.push_back(1); qStop.push_back(t[2]);
    end else begin
      qOp.push_back({41'b0, b[86:46]}); qLong.push_back(0); qStop.push_back(t[1]);
      qOp.push_back({41'b0, b[127:87]}); qLong.push_back(0); qStop.push_back(t[2]);
    end
  endtask

  function automatic logic [4:0] pickTemplate(input int idx);
    case (idx)
      0: return 5'd4;   // one full group
      1: return 5'd1;   // stop after slot 0
      2: return 5'd8;   // merge, no stop
      3: return 5'd16;  // reserved
      4: return 5'd10;  // merge with inner stop: undefined
      5: return 5'd12;  // merge, stop at end
      6: return 5'd0;
      7: return 5'd0;
      8: return 5'd4;   // nine-op group
      9: return 5'd7;   // three single groups
      default: ;
    endcase
    if (idx == nTarget - 1) return 5'd4;
    if ($urandom_range(0, 7) == 0) return 5'($urandom_range(0, 31));
    return 5'($urandom_range(0, 15));
  endfunction

  task automatic stepCycle();
    int expLen;
    bit found;
    @(negedge clk);
    cyc++;
    chk(inReady == (qOp.size() <= 3), "R8", "inReady", inReady, qOp.size() <= 3);
    chk(illegalBundle == expIll, "R3", "illegalBundle", illegalBundle, expIll);
    expLen = 0; found = 0;
    for (int i = 0; i < W; i++)
      if (!found && i < qOp.size() && qStop[i]) begin found = 1; expLen = i + 1; end
    if (!found && qOp.size() >= W) expLen = W;
    chk(issueValid == (expLen != 0), "R5", "issueValid", issueValid, expLen != 0);
    if (prevStall) begin
      chk(issueValid && issueOp == prevOp && issueLaneValid == prevMask &&
          issueLong == prevLong && issueGroupEnd == prevEnd, "R7", "held chunk",
          issueOp[127:0], prevOp[127:0]);
    end
    if (issueValid && expLen != 0) begin
      for (int i = 0; i < W; i++) begin
        chk(issueLaneValid[i] == (i < expLen), "R4", "lane valid", issueLaneValid, i < expLen);
        if (i < expLen) begin
          chk(issueOp[i*OPW +: OPW] == qOp[i], "R1", "lane data", issueOp[i*OPW +: OPW], qOp[i]);
          chk(issueLong[i] == qLong[i], "R2", "long flag", issueLong[i], qLong[i]);
        end else begin
          chk(issueOp[i*OPW +: OPW] == '0 && !issueLong[i], "R4", "idle lane", issueOp[i*OPW +: OPW], 0);
        end
      end
      chk(issueGroupEnd == qStop[expLen-1], "R6", "group end", issueGroupEnd, qStop[expLen-1]);
    end
    issueReady = ((cyc % 64) < 12) ? 1'b0 : ($urandom_range(0, 3) != 0);
    prevStall = issueValid && !issueReady;
    prevOp = issueOp; prevMask = issueLaneValid; prevLong = issueLong; prevEnd = issueGroupEnd;
    if (issueValid && issueReady)
      for (int i = 0; i < expLen; i++) begin
        void'(qOp.pop_front()); void'(qLong.pop_front()); void'(qStop.pop_front());
      end
    if (acc < nTarget) begin
      inValid = ($urandom_range(0, 2) != 0);
      inBundle = mkBundle(pickTemplate(acc));
    end else begin
      inValid = 1'b0;
    end
    expIll = 0;
    if (inValid && inReady) begin
      expIll = isIllegal(inBundle[4:0]);
      pushModel(inBundle);
      acc++;
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    syncRst = 1; inValid = 0; issueReady = 0; inBundle = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!issueValid && inReady && !illegalBundle, "R9", "reset state",
        {issueValid, inReady, illegalBundle}, 3'b010);
    syncRst = 0;
    while ((acc < nTarget || qOp.size() != 0) && cyc < LIMIT) stepCycle();

    // stale operations must vanish on reset
    if (cyc < LIMIT) begin
      @(negedge clk);
      inValid = 1; issueReady = 0; inBundle = mkBundle(5'd0);
      @(negedge clk);
      inValid = 0; syncRst = 1;
      @(negedge clk);
      syncRst = 0;
      chk(!issueValid && inReady && !illegalBundle, "R9", "reset flush",
          {issueValid, inReady, illegalBundle}, 3'b010);
      qOp.delete(); qLong.delete(); qStop.delete();
      expIll = 0; prevStall = 0;
      nTarget = acc + 1;
      while ((acc < nTarget || qOp.size() != 0) && cyc < LIMIT) stepCycle();
    end

    if (cyc >= LIMIT) chk(0, "WATCHDOG", "cycles", cyc, LIMIT);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule